// File: doc/BRIEF.md
# Mode Entry Interrupt Status Logic

This block keeps the interrupt flags of a power-mode controller. It watches two kinds of event. The first is a forced entry into the safe mode, caused by a request line from the reset and fault manager. The second is the end of any mode transition, which shows as the transition-busy status bit falling. Each event sets its own pending bit. Each pending bit has a mask bit, and the block drives one registered interrupt request line from the unmasked pending bits.

Software clears a pending bit by writing a one to its position. Software programs the masks with a separate write strobe. The safe-mode flag ignores a safe entry that software asked for, and it stays set while the hardware request stays asserted. The transition-complete flag is not raised when the transition ends in one of the two halting low-power modes. That way the event that completes the entry cannot at once ask to leave the mode. The mode sequencer and the fault manager sit outside this block; they reach it only through its inputs.

Top module: `mode_irq_status`

## Requirements
- R1: A rising edge of `hw_safe_req_i` sets `pend_o[1]` (the safe-mode flag) at the clock edge where the rise is first sampled, including the first edge after reset if the line is already high.
- R2: After the safe-mode flag has been cleared, a new rising edge of `hw_safe_req_i` sets it again even when the target mode is already the safe mode.
- R3: A mode transition into the safe mode with `hw_safe_req_i` low sets no safe-mode flag; only the transition-complete flag `pend_o[0]` is set.
- R4: A clear write to bit 1 while `hw_safe_req_i` is high leaves `pend_o[1]` at 1; once the line is low the same write clears it.
- R5: A 1-to-0 change of `busy_i` sets `pend_o[0]` at the edge where the low value is first sampled.
- R6: No transition-complete flag is set when `tgt_mode_i` is Halt (4'h8) or Stop (4'hA) at that falling edge of `busy_i`.
- R7: `irq_o` equals the OR over both sources of (pending AND mask) as it stood one clock earlier; a masked pending bit raises no request.
- R8: With `clr_we_i` high, a 1 in `clr_data_i` bit 0 (transition complete) or bit 1 (safe mode) clears that pending bit; a 0 leaves it unchanged.
- R9: When a set event and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R10: With `mask_we_i` high, `mask_o` loads `mask_data_i` (bit 0 transition complete, bit 1 safe mode) at the next edge; reset clears pending bits, masks and `irq_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_safe_req_i | input | 1 | Safe-mode request level from the fault manager |
| busy_i | input | 1 | Mode transition in progress |
| tgt_mode_i | input | 4 | Mode being entered by the current transition |
| clr_we_i | input | 1 | Write strobe for the write-1-to-clear pending register |
| clr_data_i | input | 2 | Clear data, bit 0 transition complete, bit 1 safe mode |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_data_i | input | 2 | Mask data, same bit order |
| pend_o | output | 2 | Pending bits, bit 0 transition complete, bit 1 safe mode |
| mask_o | output | 2 | Current mask bits |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The edge detectors hold the block's hidden state. A wrong stored value there shows at `pend_o` at the very next edge: a spurious set, or a missing one. A stuck pending cell or a bad clear gate shows on `pend_o` one edge after the write. A fault in the request stage shows on `irq_o` exactly one edge after the pending and mask values that should have driven it. So every internal fault shows within two clock edges of the stimulus that exposes it.

// File: rtl/mode_irq_pkg.sv
package mode_irq_pkg;

  localparam int SRC_N    = 2;
  localparam int SRC_MTC  = 0;
  localparam int SRC_SAFE = 1;
  localparam int MODE_W   = 4;

  typedef enum logic [MODE_W-1:0] {
    PM_RESET   = 4'h0,
    PM_TEST    = 4'h1,
    PM_SAFE    = 4'h2,
    PM_DRUN    = 4'h3,
    PM_RUN0    = 4'h4,
    PM_RUN1    = 4'h5,
    PM_RUN2    = 4'h6,
    PM_RUN3    = 4'h7,
    PM_HALT    = 4'h8,
    PM_STOP    = 4'hA,
    PM_STANDBY = 4'hD
  } pwr_mode_e;

  // Transitions ending in a halting low-power mode raise no completion flag.
  function automatic logic mtc_suppressed(input logic [MODE_W-1:0] mode);
    return (mode == PM_HALT) || (mode == PM_STOP);
  endfunction

  // Next value of one pending cell: set has priority over an allowed clear.
  function automatic logic pend_next(input logic cur, input logic set,
                                     input logic clr, input logic hold);
    return set | (cur & ~(clr & ~hold));
  endfunction

  function automatic logic irq_reduce(input logic [SRC_N-1:0] pend,
                                      input logic [SRC_N-1:0] mask);
    return |(pend & mask);
  endfunction

endpackage

// File: rtl/mie_edge.sv
module mie_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/mie_pend_cell.sv
module mie_pend_cell
  import mode_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= pend_next(q, set_i, clr_i, hold_i);
  end

  assign q_o = q;
endmodule

// File: rtl/mie_irq_reg.sv
module mie_irq_reg
  import mode_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] pend_i,
  input  logic [SRC_N-1:0] mask_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_reduce(pend_i, mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mode_irq_status.sv
module mode_irq_status
  import mode_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_safe_req_i,
  input  logic              busy_i,
  input  logic [MODE_W-1:0] tgt_mode_i,
  input  logic              clr_we_i,
  input  logic [SRC_N-1:0]  clr_data_i,
  input  logic              mask_we_i,
  input  logic [SRC_N-1:0]  mask_data_i,
  output logic [SRC_N-1:0]  pend_o,
  output logic [SRC_N-1:0]  mask_o,
  output logic              irq_o
);
  // Named internal events, visible to the checker.
  logic safe_rise_w;
  logic busy_fall_w;
  logic safe_set;
  logic mtc_set;
  logic safe_clr_blocked;

  logic [1:0] edge_in;
  logic [1:0] edge_rise;
  logic [1:0] edge_fall;

  assign edge_in = {hw_safe_req_i, busy_i};

  mie_edge #(.W(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (edge_in),
    .rise_o (edge_rise),
    .fall_o (edge_fall)
  );

  assign safe_rise_w      = edge_rise[1];
  assign busy_fall_w      = edge_fall[0];
  assign safe_set         = safe_rise_w;
  assign mtc_set          = busy_fall_w & ~mtc_suppressed(tgt_mode_i);
  assign safe_clr_blocked = hw_safe_req_i;

  logic [SRC_N-1:0] set_vec;
  logic [SRC_N-1:0] hold_vec;
  logic [SRC_N-1:0] clr_vec;

  always_comb begin
    set_vec            = '0;
    hold_vec           = '0;
    set_vec[SRC_MTC]   = mtc_set;
    set_vec[SRC_SAFE]  = safe_set;
    hold_vec[SRC_SAFE] = safe_clr_blocked;
  end

  assign clr_vec = clr_we_i ? clr_data_i : '0;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    mie_pend_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .hold_i (hold_vec[i]),
      .q_o    (pend_o[i])
    );
  end

  logic [SRC_N-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_data_i;
  end

  assign mask_o = mask_q;

  mie_irq_reg u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_o),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/mode_irq_status_chk.sv
module mode_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_safe_req_i,
  input logic [3:0] tgt_mode_i,
  input logic       clr_we_i,
  input logic [1:0] clr_data_i,
  input logic [1:0] pend_o,
  input logic [1:0] mask_o,
  input logic       irq_o,
  input logic       safe_set,
  input logic       mtc_set,
  input logic       busy_fall_w
);
  // R1
  safe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    safe_set |=> pend_o[1]);

  // R4
  safe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[1] && hw_safe_req_i) |=> pend_o[1]);

  // R5
  mtc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mtc_set |=> pend_o[0]);

  // R6
  mtc_lowpower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_fall_w && (tgt_mode_i == 4'h8 || tgt_mode_i == 4'hA) && !pend_o[0])
      |=> !pend_o[0]);

  // R7
  irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_o & mask_o)) |=> irq_o);

  // R7
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_o & mask_o)) |=> !irq_o);

  // R8
  write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && clr_data_i == 2'b00 && pend_o[0]) |=> pend_o[0]);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (safe_set && clr_we_i && clr_data_i[1]) |=> pend_o[1]);
endmodule

bind mode_irq_status mode_irq_status_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hw_safe_req_i (hw_safe_req_i),
  .tgt_mode_i    (tgt_mode_i),
  .clr_we_i      (clr_we_i),
  .clr_data_i    (clr_data_i),
  .pend_o        (pend_o),
  .mask_o        (mask_o),
  .irq_o         (irq_o),
  .safe_set      (safe_set),
  .mtc_set       (mtc_set),
  .busy_fall_w   (busy_fall_w)
);

// File: tb/test_mode_irq_status.sv
module test_mode_irq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_safe_req_i = 1'b0;
  logic       busy_i = 1'b0;
  logic [3:0] tgt_mode_i = 4'h4;
  logic       clr_we_i = 1'b0;
  logic [1:0] clr_data_i = 2'b00;
  logic       mask_we_i = 1'b0;
  logic [1:0] mask_data_i = 2'b00;
  logic [1:0] pend_o;
  logic [1:0] mask_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mode_irq_status i_mode_irq_status (
    .clk(clk), .rst_n(rst_n), .hw_safe_req_i(hw_safe_req_i), .busy_i(busy_i),
    .tgt_mode_i(tgt_mode_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .mask_we_i(mask_we_i), .mask_data_i(mask_data_i),
    .pend_o(pend_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic       hw;
    logic       busy;
    logic [3:0] tgt;
    logic       cw;
    logic [1:0] cd;
    logic       mw;
    logic [1:0] md;
    logic [1:0] ep;
    logic [1:0] em;
    logic       ei;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 28;
  // hw busy tgt cw cd mw md | exp pend, exp mask, exp irq | requirement
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,4'h4,1'b0,2'b00,1'b1,2'b11, 2'b00,2'b11,1'b0, 4'd10}, // R10 mask load
    '{1'b0,1'b1,4'h5,1'b0,2'b00,1'b0,2'b00, 2'b00,2'b11,1'b0, 4'd5},
    '{1'b0,1'b0,4'h5,1'b0,2'b00,1'b0,2'b00, 2'b01,2'b11,1'b0, 4'd5},  // R5 busy fall
    '{1'b0,1'b0,4'h5,1'b0,2'b00,1'b0,2'b00, 2'b01,2'b11,1'b1, 4'd7},  // R7 irq one later
    '{1'b0,1'b0,4'h5,1'b1,2'b01,1'b0,2'b00, 2'b00,2'b11,1'b1, 4'd8},  // R8 clear
    '{1'b0,1'b0,4'h5,1'b0,2'b00,1'b0,2'b00, 2'b00,2'b11,1'b0, 4'd7},
    '{1'b0,1'b1,4'h8,1'b0,2'b00,1'b0,2'b00, 2'b00,2'b11,1'b0, 4'd6},
    '{1'b0,1'b0,4'h8,1'b0,2'b00,1'b0,2'b00, 2'b00,2'b11,1'b0, 4'd6},  // R6 halt
    '{1'b0,1'b1,4'hA,1'b0,2'b00,1'b0,2'b00, 2'b00,2'b11,1'b0, 4'd6},
    '{1'b0,1'b0,4'hA,1'b0,2'b00,1'b0,2'b00, 2'b00,2'b11,1'b0, 4'd6},  // R6 stop
    '{1'b0,1'b1,4'h2,1'b0,2'b00,1'b0,2'b00, 2'b00,2'b11,1'b0, 4'd3},
    '{1'b0,1'b0,4'h2,1'b0,2'b00,1'b0,2'b00, 2'b01,2'b11,1'b0, 4'd3},  // R3 sw safe entry
    '{1'b0,1'b0,4'h2,1'b1,2'b01,1'b0,2'b00, 2'b00,2'b11,1'b1, 4'd8},
    '{1'b1,1'b0,4'h2,1'b0,2'b00,1'b0,2'b00, 2'b10,2'b11,1'b0, 4'd1},  // R1 hw rise
    '{1'b1,1'b0,4'h2,1'b1,2'b10,1'b0,2'b00, 2'b10,2'b11,1'b1, 4'd4},  // R4 blocked clear
    '{1'b0,1'b0,4'h2,1'b1,2'b00,1'b0,2'b00, 2'b10,2'b11,1'b1, 4'd8},  // R8 write zero
    '{1'b0,1'b0,4'h2,1'b1,2'b10,1'b0,2'b00, 2'b00,2'b11,1'b1, 4'd4},  // R4 clear allowed
    '{1'b1,1'b0,4'h2,1'b0,2'b00,1'b0,2'b00, 2'b10,2'b11,1'b0, 4'd1},
    '{1'b0,1'b0,4'h2,1'b1,2'b10,1'b0,2'b00, 2'b00,2'b11,1'b1, 4'd8},
    '{1'b1,1'b0,4'h2,1'b0,2'b00,1'b0,2'b00, 2'b10,2'b11,1'b0, 4'd2},  // R2 again in safe
    '{1'b0,1'b0,4'h2,1'b1,2'b10,1'b0,2'b00, 2'b00,2'b11,1'b1, 4'd8},
    '{1'b1,1'b0,4'h2,1'b1,2'b10,1'b0,2'b00, 2'b10,2'b11,1'b0, 4'd9},  // R9 set wins safe
    '{1'b1,1'b0,4'h2,1'b0,2'b00,1'b1,2'b00, 2'b10,2'b00,1'b1, 4'd10}, // R10 mask off
    '{1'b1,1'b0,4'h2,1'b0,2'b00,1'b0,2'b00, 2'b10,2'b00,1'b0, 4'd7},  // R7 masked
    '{1'b0,1'b1,4'h6,1'b1,2'b10,1'b0,2'b00, 2'b00,2'b00,1'b0, 4'd8},
    '{1'b0,1'b0,4'h6,1'b1,2'b01,1'b0,2'b00, 2'b01,2'b00,1'b0, 4'd9},  // R9 set wins mtc
    '{1'b0,1'b0,4'h6,1'b0,2'b00,1'b1,2'b01, 2'b01,2'b01,1'b0, 4'd10},
    '{1'b0,1'b0,4'h6,1'b0,2'b00,1'b0,2'b00, 2'b01,2'b01,1'b1, 4'd7}   // R7
  };

  task automatic check(input logic [1:0] act, input logic [1:0] exp,
                       input int tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R10 reset state
    check(pend_o, 2'b00, 10, "reset pend");
    check(mask_o, 2'b00, 10, "reset mask");
    check({1'b0, irq_o}, 2'b00, 10, "reset irq");
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      hw_safe_req_i = VEC[k].hw;
      busy_i        = VEC[k].busy;
      tgt_mode_i    = VEC[k].tgt;
      clr_we_i      = VEC[k].cw;
      clr_data_i    = VEC[k].cd;
      mask_we_i     = VEC[k].mw;
      mask_data_i   = VEC[k].md;
      @(posedge clk);
      #5;
      check(pend_o, VEC[k].ep, int'(VEC[k].tag), $sformatf("row %0d pend", k));
      check(mask_o, VEC[k].em, int'(VEC[k].tag), $sformatf("row %0d mask", k));
      check({1'b0, irq_o}, {1'b0, VEC[k].ei}, int'(VEC[k].tag),
            $sformatf("row %0d irq", k));
    end

    // R10 reset in the middle of activity clears everything
    @(negedge clk);
    clr_we_i = 1'b0; mask_we_i = 1'b0;
    hw_safe_req_i = 1'b1;
    rst_n = 1'b0;
    #5;
    check(pend_o, 2'b00, 10, "mid reset pend");
    check(mask_o, 2'b00, 10, "mid reset mask");
    check({1'b0, irq_o}, 2'b00, 10, "mid reset irq");

    // R1 request already high when reset ends is seen as a new rise
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    check(pend_o, 2'b10, 1, "safe set after reset");
    @(posedge clk);
    #5;
    check({1'b0, irq_o}, 2'b00, 7, "masked after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule